// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block drives one active-low interrupt line whose shape is chosen by a 3-bit selection code. Two codes give static levels: released high, or held low. Two codes give free-running square waves with 50% duty: one at 2 Hz and one at 1 Hz. The remaining four codes are level modes. In a level mode, a calendar boundary (second, minute, hour or month) pulls the line low. The line stays low until software writes zero to a status flag.

The time base arrives from outside the block. A 2 Hz square wave falls at every half-second boundary, and one-cycle strobes mark the second, minute, hour and month rollovers. The second strobe coincides with every other falling edge of the 2 Hz wave. The block does no time counting of its own. Software reads the flag through `flagO` and clears it through a small write port.

Changing the selection code discards any latched level-mode event. This keeps an event caught under the old mode from showing under the new one.

Top module: `perint_gen`

## Requirements
- R1: After reset, the selection is 000, `intNO` is 1 and `flagO` is 0.
- R2: With code 000 applied, `intNO` is 1 from the next cycle on. With code 001 applied, it is 0 from the next cycle on.
- R3: Under code 010, `intNO` equals the value that `base2HzI` had one cycle earlier.
- R4: Under code 011, `intNO` goes to 0 in the cycle after a second strobe (`evtTickI[0]`). It inverts in the cycle after each other falling edge of `base2HzI`. The result is a 1 Hz, 50% wave that is low for the first half of each second.
- R5: Under code 100+k (k = 0 second, 1 minute, 2 hour, 3 month), a strobe on `evtTickI[k]` sets `flagO` to 1 and `intNO` to 0 in the next cycle. Strobes on other bits leave both unchanged.
- R6: In a level mode, a flag write with data 0 returns `flagO` to 0 and `intNO` to 1 in the next cycle. A flag write with data 1 changes nothing.
- R7: If a selected event and a clearing write occur in the same cycle, the event wins and `flagO` is 1 in the next cycle.
- R8: In the cycle after the selection code changes, `flagO` is 0, even if a strobe arrives in the changing cycle.
- R9: Under codes 000 to 011, `flagO` stays 0 whatever strobes or writes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selI | input | 3 | Mode selection code |
| base2HzI | input | 1 | 2 Hz, 50% time-base wave; falls at each half-second boundary |
| evtTickI | input | 4 | One-cycle boundary strobes: bit 0 second, 1 minute, 2 hour, 3 month |
| flagWrEnI | input | 1 | Flag write strobe |
| flagWrDataI | input | 1 | Flag write data; only 0 has an effect |
| intNO | output | 1 | Active-low periodic interrupt |
| flagO | output | 1 | Latched level-mode event flag |

## Verification
The latch flag has three sources that can act in the same cycle: a selected boundary strobe, a clearing write from software, and a change of the selection code. Directed cycles place a strobe together with a zero write, and a strobe together with a code change. The checks then confirm that the event beats the write and that the code change beats the event. The random phase mixes all three at a rate where collisions recur. Every cycle is judged against a bench model of the flag and the output that applies the same precedence.

// File: rtl/perint_pkg.sv
package perint_pkg;
  localparam int SEL_W     = 3;
  localparam int EVT_N     = 4;
  localparam int EVT_IDX_W = $clog2(EVT_N);
  localparam int LVL_BASE  = 4;

  typedef enum logic [SEL_W-1:0] {
    MODE_OFF   = 3'b000,
    MODE_LOW   = 3'b001,
    MODE_SQ2   = 3'b010,
    MODE_SQ1   = 3'b011,
    MODE_SEC   = 3'b100,
    MODE_MIN   = 3'b101,
    MODE_HOUR  = 3'b110,
    MODE_MONTH = 3'b111
  } mode_e;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic selChange;
    logic baseFall;
    logic secAlign;
  } ctrl_strb_t;
endpackage

// File: rtl/perint_ctrl.sv
module perint_ctrl
  import perint_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selI,
  input  logic             base2HzI,
  input  logic [EVT_N-1:0] evtTickI,
  input  logic             flagWrEnI,
  input  logic             flagWrDataI,
  output mode_e            modeO,
  output logic             baseQO,
  output ctrl_strb_t       strbO
);
  mode_e selQ;
  logic baseQ;
  logic [EVT_N-1:0] evtHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= MODE_OFF;
      baseQ <= 1'b0;
    end else begin
      selQ  <= mode_e'(selI);
      baseQ <= base2HzI;
    end
  end

  for (genvar i = 0; i < EVT_N; i++) begin : g_hit
    localparam logic [SEL_W-1:0] CODE = SEL_W'(LVL_BASE + i);
    assign evtHit[i] = evtTickI[i] && (selQ == CODE);
  end

  always_comb begin
    strbO.setFlag   = |evtHit;
    strbO.clrFlag   = flagWrEnI && !flagWrDataI;
    strbO.selChange = (selI != selQ);
    strbO.baseFall  = baseQ && !base2HzI;
    strbO.secAlign  = evtTickI[0];
  end

  assign modeO  = selQ;
  assign baseQO = baseQ;
endmodule

// File: rtl/perint_dp.sv
module perint_dp
  import perint_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  mode_e      modeI,
  input  logic       baseQI,
  input  ctrl_strb_t strbI,
  output logic       intNO,
  output logic       flagO
);
  logic flagQ;
  logic phaseQ;
  logic isLevel;

  assign isLevel = modeI[SEL_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strbI.selChange) begin
      flagQ <= 1'b0;
    end else if (strbI.setFlag) begin
      flagQ <= 1'b1;
    end else if (strbI.clrFlag) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= 1'b1;
    end else if (strbI.secAlign) begin
      phaseQ <= 1'b0;
    end else if (strbI.baseFall) begin
      phaseQ <= !phaseQ;
    end
  end

  always_comb begin
    unique case (modeI)
      MODE_OFF: intNO = 1'b1;
      MODE_LOW: intNO = 1'b0;
      MODE_SQ2: intNO = baseQI;
      MODE_SQ1: intNO = phaseQ;
      default:  intNO = !flagQ;
    endcase
  end

  assign flagO = flagQ;

  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (strbI.setFlag && !strbI.selChange) |=> flagQ);
  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strbI.clrFlag && !strbI.setFlag && !strbI.selChange) |=> !flagQ);
  a_r8_change_clears: assert property (@(posedge clk) disable iff (!rstN)
    strbI.selChange |=> !flagQ);
  a_r9_no_flag_outside_level: assert property (@(posedge clk) disable iff (!rstN)
    !isLevel |-> !flagQ);
  a_r4_second_aligns: assert property (@(posedge clk) disable iff (!rstN)
    strbI.secAlign |=> !phaseQ);
endmodule

// File: rtl/perint_gen.sv
module perint_gen
  import perint_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selI,
  input  logic             base2HzI,
  input  logic [EVT_N-1:0] evtTickI,
  input  logic             flagWrEnI,
  input  logic             flagWrDataI,
  output logic             intNO,
  output logic             flagO
);
  mode_e      mode;
  logic       baseQ;
  ctrl_strb_t strb;

  perint_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selI(selI), .base2HzI(base2HzI),
    .evtTickI(evtTickI), .flagWrEnI(flagWrEnI), .flagWrDataI(flagWrDataI),
    .modeO(mode), .baseQO(baseQ), .strbO(strb)
  );

  perint_dp u_dp (
    .clk(clk), .rstN(rstN), .modeI(mode), .baseQI(baseQ), .strbI(strb),
    .intNO(intNO), .flagO(flagO)
  );
endmodule

// File: tb/perint_gen_bench.sv
module perint_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] sel = 3'b000;
  logic base = 1'b0;
  logic [3:0] evt = 4'b0000;
  logic we = 1'b0, wd = 1'b0;
  logic intN, flag;

  always #5 clk = ~clk;

  perint_gen u_perint_gen (
    .clk(clk), .rstN(rstN), .selI(sel), .base2HzI(base), .evtTickI(evt),
    .flagWrEnI(we), .flagWrDataI(wd), .intNO(intN), .flagO(flag)
  );

  int nChk = 0, nFail = 0, genCnt = 0;
  logic [2:0] mSel = 3'b000;
  logic mBaseQ = 1'b0, mFlag = 1'b0, mPhase = 1'b1;

  function automatic logic expIntN();
    case (mSel)
      3'd0: return 1'b1;
      3'd1: return 1'b0;
      3'd2: return mBaseQ;
      3'd3: return mPhase;
      default: return !mFlag;
    endcase
  endfunction

  function automatic string outTag();
    case (mSel)
      3'd0, 3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelStep(logic [2:0] s, logic b, logic [3:0] e, logic w, logic d);
    logic hit;
    hit = mSel[2] && e[mSel[1:0]];
    if (s != mSel) mFlag = 1'b0;
    else if (hit) mFlag = 1'b1;
    else if (w && !d) mFlag = 1'b0;
    if (e[0]) mPhase = 1'b0;
    else if (mBaseQ && !b) mPhase = !mPhase;
    mBaseQ = b;
    mSel = s;
  endtask

  task automatic runCycle(logic [2:0] s, logic [3:0] extra, logic w, logic d,
                          string tagI, string tagF);
    base = ((genCnt % 40) >= 20);
    evt = extra;
    evt[0] = (genCnt == 0) || extra[0];
    sel = s; we = w; wd = d;
    @(posedge clk);
    modelStep(sel, base, evt, we, wd);
    genCnt = (genCnt + 1) % 80;
    @(negedge clk);
    chk((tagI == "") ? outTag() : tagI, "intN", intN, expIntN());
    chk((tagF == "") ? (mSel[2] ? "R6" : "R9") : tagF, "flag", flag, mFlag);
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [2:0] rs;
    seed = $urandom(32'h1a2b);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1", "intN", intN, 1'b1);
    chk("R1", "flag", flag, 1'b0);

    runCycle(3'd1, 4'b0000, 0, 0, "R2", "R9");
    runCycle(3'd1, 4'b0000, 0, 0, "R2", "R9");
    runCycle(3'd0, 4'b0000, 0, 0, "R2", "R9");

    runCycle(3'd4, 4'b0000, 0, 0, "R8", "R8");
    runCycle(3'd4, 4'b0001, 0, 0, "R5", "R5");
    runCycle(3'd4, 4'b0000, 1, 1, "R6", "R6");
    runCycle(3'd4, 4'b0000, 1, 0, "R6", "R6");

    runCycle(3'd5, 4'b0000, 0, 0, "R8", "R8");
    runCycle(3'd5, 4'b1101, 0, 0, "R5", "R5");
    runCycle(3'd5, 4'b0010, 1, 0, "R7", "R7");
    runCycle(3'd5, 4'b0000, 0, 0, "R7", "R7");

    runCycle(3'd6, 4'b0100, 0, 0, "R8", "R8");
    runCycle(3'd6, 4'b0100, 0, 0, "R5", "R5");
    runCycle(3'd7, 4'b1000, 0, 0, "R8", "R8");
    runCycle(3'd7, 4'b1000, 1, 0, "R7", "R7");

    runCycle(3'd3, 4'b1110, 0, 0, "R8", "R8");
    for (int i = 0; i < 240; i++) runCycle(3'd3, 4'b1110, i[2], 1'b0, "R4", "R9");
    for (int i = 0; i < 160; i++) runCycle(3'd2, 4'b1110, i[1], i[3], "R3", "R9");

    rs = 3'd4;
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ex;
      if (($urandom % 64) == 0) rs = 3'($urandom);
      ex = {(($urandom % 16) == 0), (($urandom % 16) == 0), (($urandom % 16) == 0), 1'b0};
      runCycle(rs, ex, (($urandom % 8) == 0), 1'($urandom), "", "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule